// File: doc/BRIEF.md
# Conditional Stream Routing Network

This block sits between a row of lock-step processing lanes and an equal number of striped memory banks. It moves one stream transfer per cycle in either direction. A stream is laid out so that the element at linear position p lives in bank p mod LANES, at row p / LANES. The caller supplies the current head position of the stream and a per-lane mask. The block works out which lane talks to which bank, so no lane ever needs to track a memory location.

On a write, the block packs the data of the enabled lanes together with no holes. The packed run then lands in consecutive stream positions starting at the head, wrapping around the banks. On a read, the memory side presents the LANES-wide window that starts at the head. The block hands consecutive elements to the requesting lanes in ascending lane order. Lanes that do not request anything receive nothing and consume no element. Each transfer also reports how many elements moved and the head position after the transfer, so a channel pointer can advance by exactly that amount.

The datapath is a logarithmic rotator plus a mask-driven packer, which compacts on writes and expands on reads. A single register stage follows it, so all results appear one cycle after the request. LANES must be a power of two and at least 2.

Top module: `stream_router`

## Requirements
- R1: A transfer requested with `xfer_valid` high in one cycle produces its results on the outputs at the next rising edge. `done_valid` is high in exactly the cycles that follow a requested transfer.
- R2: For a transfer, `moved_cnt` equals the number of set bits in `lane_mask`.
- R3: After a transfer, `next_head` equals `head_pos + moved_cnt` modulo 2^POS_W. When no transfer was requested, `next_head` keeps its previous value.
- R4: On a write, the k-th enabled lane, counting from zero in ascending lane index among lanes with their mask bit set, drives its data to bank (head_pos + k) mod LANES. During any transfer, `bank_row` for bank b is the row (position >> log2(LANES)) of the window position head_pos + ((b - head_pos) mod LANES). When idle, `bank_row` is zero.
- R5: On a write, exactly `moved_cnt` bank enables are raised. They occupy the contiguous run of banks that starts at bank head_pos mod LANES and wraps past the last bank. Banks that are not enabled carry zero data.
- R6: On a read, bank b's input holds the element at position head_pos + ((b - head_pos) mod LANES). The k-th requesting lane, counting from zero in ascending lane index, receives the element at position head_pos + k.
- R7: On a read, `pe_rvalid` equals the request mask. Lanes that do not request anything get zero data.
- R8: `xfer_write` = 1 selects a write (lanes to banks) and 0 selects a read (banks to lanes). `done_is_write` reports the direction of the completed transfer. A write never raises `pe_rvalid`, and a read never raises `bank_we`.
- R9: An idle cycle, or a transfer with an all-zero mask, yields no bank enables, no lane valids, a zero count and zero data.
- R10: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_valid | input | 1 | A transfer is requested this cycle |
| xfer_write | input | 1 | 1 = write (lanes to banks), 0 = read (banks to lanes) |
| head_pos | input | POS_W | Stream position at the head of this transfer |
| lane_mask | input | LANES | Per-lane condition: enables a write or requests a read |
| pe_wdata | input | LANES*DATA_W | Lane write data, lane i in slice i |
| bank_rdata | input | LANES*DATA_W | Window read data, bank b in slice b |
| done_valid | output | 1 | A transfer completed (registered) |
| done_is_write | output | 1 | Direction of the completed transfer |
| moved_cnt | output | log2(LANES)+1 | Elements moved by the completed transfer |
| next_head | output | POS_W | Head position after the completed transfer |
| bank_we | output | LANES | Per-bank write enable |
| bank_wdata | output | LANES*DATA_W | Per-bank write data |
| bank_row | output | LANES*(POS_W-log2(LANES)) | Per-bank row of the served window position |
| pe_rvalid | output | LANES | Per-lane read data valid |
| pe_rdata | output | LANES*DATA_W | Per-lane read data |

## Verification
The wrap of the packed run across the bank boundary and the wrap of the position counter past 2^POS_W can happen in the same cycle. The bench provokes this with heads placed just below the top of the position range and sparse masks. The packed run must then continue from the last bank into bank 0 while the rows and `next_head` roll over to zero. It also issues reads and writes back to back, with heads taken both from the running stream pointer and at random. Every cycle's lane and bank outputs are judged against a behavioural model that walks the mask lane by lane with a running element counter.

// File: rtl/stream_route_pkg.sv
package stream_route_pkg;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } route_dir_e;

    // index width for a lane/bank number; at least one bit
    function automatic int lane_idx_w(input int lanes);
        return (lanes < 2) ? 1 : $clog2(lanes);
    endfunction

endpackage

// File: rtl/lane_rank.sv
// Prefix population count: rank[i] = number of set mask bits below lane i.
module lane_rank #(
    parameter int LANES = 4,
    parameter int CNT_W = 3
) (
    input  logic [LANES-1:0]            mask,
    output logic [LANES-1:0][CNT_W-1:0] rank,
    output logic [CNT_W-1:0]            total
);

    always_comb begin
        logic [CNT_W-1:0] run;
        run = '0;
        for (int i = 0; i < LANES; i++) begin
            rank[i] = run;
            run     = run + CNT_W'(mask[i]);
        end
        total = run;
    end

endmodule

// File: rtl/bank_rotator.sv
// Logarithmic rotator. Gather: dout[j] = din[(j+amt) mod LANES].
// Scatter: dout[(j+amt) mod LANES] = din[j].
module bank_rotator #(
    parameter int LANES   = 4,
    parameter int ELEM_W  = 33,
    parameter bit SCATTER = 1'b0,
    localparam int IDX_W  = stream_route_pkg::lane_idx_w(LANES)
) (
    input  logic [LANES-1:0][ELEM_W-1:0] din,
    input  logic [IDX_W-1:0]             amt,
    output logic [LANES-1:0][ELEM_W-1:0] dout
);

    logic [LANES-1:0][ELEM_W-1:0] stg [IDX_W+1];

    assign stg[0] = din;

    for (genvar s = 0; s < IDX_W; s++) begin : g_stage
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            localparam int STEP = (1 << s) % LANES;
            localparam int SRC  = SCATTER ? ((j - STEP + LANES) % LANES)
                                          : ((j + STEP) % LANES);
            assign stg[s+1][j] = amt[s] ? stg[s][SRC] : stg[s][j];
        end
    end

    assign dout = stg[IDX_W];

endmodule

// File: rtl/lane_packer.sv
// Mask-driven packer. Compact: slot k takes the lane of rank k.
// Expand: lane i takes slot rank[i]. Unselected outputs are zero.
module lane_packer #(
    parameter int LANES  = 4,
    parameter int ELEM_W = 33,
    parameter int CNT_W  = 3,
    parameter bit EXPAND = 1'b0
) (
    input  logic [LANES-1:0]             mask,
    input  logic [LANES-1:0][CNT_W-1:0]  rank,
    input  logic [LANES-1:0][ELEM_W-1:0] din,
    output logic [LANES-1:0][ELEM_W-1:0] dout
);

    if (EXPAND) begin : g_expand
        always_comb begin
            dout = '0;
            for (int i = 0; i < LANES; i++) begin
                for (int k = 0; k < LANES; k++) begin
                    if (mask[i] && (rank[i] == CNT_W'(k))) begin
                        dout[i] = din[k];
                    end
                end
            end
        end
    end else begin : g_compact
        always_comb begin
            dout = '0;
            for (int k = 0; k < LANES; k++) begin
                for (int i = 0; i < LANES; i++) begin
                    if (mask[i] && (rank[i] == CNT_W'(k))) begin
                        dout[k] = din[i];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/stream_router.sv
module stream_router #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int POS_W  = 16,
    localparam int IDX_W = stream_route_pkg::lane_idx_w(LANES),
    localparam int CNT_W = IDX_W + 1,
    localparam int ROW_W = POS_W - IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    xfer_valid,
    input  logic                    xfer_write,
    input  logic [POS_W-1:0]        head_pos,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [LANES*DATA_W-1:0] pe_wdata,
    input  logic [LANES*DATA_W-1:0] bank_rdata,
    output logic                    done_valid,
    output logic                    done_is_write,
    output logic [CNT_W-1:0]        moved_cnt,
    output logic [POS_W-1:0]        next_head,
    output logic [LANES-1:0]        bank_we,
    output logic [LANES*DATA_W-1:0] bank_wdata,
    output logic [LANES*ROW_W-1:0]  bank_row,
    output logic [LANES-1:0]        pe_rvalid,
    output logic [LANES*DATA_W-1:0] pe_rdata
);
    import stream_route_pkg::*;

    localparam int ELEM_W = DATA_W + 1;

    typedef struct packed {
        logic                         done;
        logic                         is_wr;
        logic [CNT_W-1:0]             cnt;
        logic [POS_W-1:0]             nhead;
        logic [LANES-1:0]             we;
        logic [LANES-1:0][DATA_W-1:0] wdata;
        logic [LANES-1:0][ROW_W-1:0]  row;
        logic [LANES-1:0]             rvalid;
        logic [LANES-1:0][DATA_W-1:0] rdata;
    } route_state_t;

    route_state_t st_d, st_q;

    logic [LANES-1:0][DATA_W-1:0] wd_lane, rd_bank;
    logic [LANES-1:0][CNT_W-1:0]  rank;
    logic [CNT_W-1:0]             total;
    logic [IDX_W-1:0]             rot_amt;
    logic [LANES-1:0][ELEM_W-1:0] wr_in, wr_packed, wr_banked;
    logic [LANES-1:0][ELEM_W-1:0] rd_in, rd_slots, rd_lanes;
    logic [LANES-1:0][ROW_W-1:0]  win_row;

    assign wd_lane = pe_wdata;
    assign rd_bank = bank_rdata;
    assign rot_amt = head_pos[IDX_W-1:0];

    // shared prefix count of the condition mask
    lane_rank #(.LANES(LANES), .CNT_W(CNT_W)) u_rank (
        .mask  (lane_mask),
        .rank  (rank),
        .total (total)
    );

    // write path: pack enabled lanes, then scatter to banks from the head
    for (genvar i = 0; i < LANES; i++) begin : g_wr_tag
        assign wr_in[i] = {1'b1, wd_lane[i]};
        assign rd_in[i] = {1'b1, rd_bank[i]};
    end

    lane_packer #(.LANES(LANES), .ELEM_W(ELEM_W), .CNT_W(CNT_W), .EXPAND(1'b0)) u_compact (
        .mask (lane_mask),
        .rank (rank),
        .din  (wr_in),
        .dout (wr_packed)
    );

    bank_rotator #(.LANES(LANES), .ELEM_W(ELEM_W), .SCATTER(1'b1)) u_wr_rot (
        .din  (wr_packed),
        .amt  (rot_amt),
        .dout (wr_banked)
    );

    // read path: gather the window into stream order, then expand to lanes
    bank_rotator #(.LANES(LANES), .ELEM_W(ELEM_W), .SCATTER(1'b0)) u_rd_rot (
        .din  (rd_in),
        .amt  (rot_amt),
        .dout (rd_slots)
    );

    lane_packer #(.LANES(LANES), .ELEM_W(ELEM_W), .CNT_W(CNT_W), .EXPAND(1'b1)) u_expand (
        .mask (lane_mask),
        .rank (rank),
        .din  (rd_slots),
        .dout (rd_lanes)
    );

    // row served by each bank inside the window that starts at the head
    for (genvar b = 0; b < LANES; b++) begin : g_row
        logic [IDX_W-1:0] offs;
        logic [POS_W-1:0] pos;
        assign offs       = IDX_W'(b) - rot_amt;
        assign pos        = head_pos + POS_W'(offs);
        assign win_row[b] = pos[POS_W-1:IDX_W];
    end

    always_comb begin
        st_d       = '0;
        st_d.nhead = st_q.nhead;
        if (xfer_valid) begin
            st_d.done  = 1'b1;
            st_d.is_wr = xfer_write;
            st_d.cnt   = total;
            st_d.nhead = head_pos + POS_W'(total);
            st_d.row   = win_row;
            if (route_dir_e'(xfer_write) == DIR_WRITE) begin
                for (int b = 0; b < LANES; b++) begin
                    st_d.we[b]    = wr_banked[b][DATA_W];
                    st_d.wdata[b] = wr_banked[b][DATA_W-1:0];
                end
            end else begin
                for (int i = 0; i < LANES; i++) begin
                    st_d.rvalid[i] = rd_lanes[i][DATA_W];
                    st_d.rdata[i]  = rd_lanes[i][DATA_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_valid    = st_q.done;
    assign done_is_write = st_q.is_wr;
    assign moved_cnt     = st_q.cnt;
    assign next_head     = st_q.nhead;
    assign bank_we       = st_q.we;
    assign bank_wdata    = st_q.wdata;
    assign bank_row      = st_q.row;
    assign pe_rvalid     = st_q.rvalid;
    assign pe_rdata      = st_q.rdata;

endmodule

// File: rtl/stream_route_chk.sv
module stream_route_chk #(
    parameter int LANES  = 4,
    parameter int POS_W  = 16,
    localparam int IDX_W = stream_route_pkg::lane_idx_w(LANES),
    localparam int CNT_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_valid,
    input logic             xfer_write,
    input logic [POS_W-1:0] head_pos,
    input logic [LANES-1:0] lane_mask,
    input logic             done_valid,
    input logic             done_is_write,
    input logic [CNT_W-1:0] moved_cnt,
    input logic [POS_W-1:0] next_head,
    input logic [LANES-1:0] bank_we,
    input logic [LANES-1:0] pe_rvalid
);

    // R1
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> done_valid);

    // R1
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_valid |=> !done_valid);

    // R2
    count_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> moved_cnt == CNT_W'($countones($past(lane_mask))));

    // R3
    head_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> next_head == $past(head_pos) + POS_W'(moved_cnt));

    // R3
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_valid |=> $stable(next_head));

    // R5
    we_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_is_write) |-> CNT_W'($countones(bank_we)) == moved_cnt);

    // R7
    rvalid_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_write) |=> pe_rvalid == $past(lane_mask));

    // R8
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_we) |-> (pe_rvalid == '0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_valid |-> (bank_we == '0 && pe_rvalid == '0 && moved_cnt == '0));

endmodule

bind stream_router stream_route_chk #(.LANES(LANES), .POS_W(POS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .xfer_valid    (xfer_valid),
    .xfer_write    (xfer_write),
    .head_pos      (head_pos),
    .lane_mask     (lane_mask),
    .done_valid    (done_valid),
    .done_is_write (done_is_write),
    .moved_cnt     (moved_cnt),
    .next_head     (next_head),
    .bank_we       (bank_we),
    .pe_rvalid     (pe_rvalid)
);

// File: tb/sim_stream_router.sv
`timescale 1ns/1ps
module sim_stream_router;

    localparam int N   = 4;
    localparam int DW  = 32;
    localparam int PW  = 16;
    localparam int IW  = 2;
    localparam int CW  = IW + 1;
    localparam int RW  = PW - IW;
    localparam int PMOD = 1 << PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_valid = 1'b0;
    logic xfer_write = 1'b0;
    logic [PW-1:0] head_pos = '0;
    logic [N-1:0] lane_mask = '0;
    logic [N*DW-1:0] pe_wdata = '0;
    logic [N*DW-1:0] bank_rdata = '0;
    logic done_valid, done_is_write;
    logic [CW-1:0] moved_cnt;
    logic [PW-1:0] next_head;
    logic [N-1:0] bank_we, pe_rvalid;
    logic [N*DW-1:0] bank_wdata, pe_rdata;
    logic [N*RW-1:0] bank_row;

    always #2.5 clk = ~clk;

    stream_router #(.LANES(N), .DATA_W(DW), .POS_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_write(xfer_write),
        .head_pos(head_pos), .lane_mask(lane_mask), .pe_wdata(pe_wdata),
        .bank_rdata(bank_rdata), .done_valid(done_valid), .done_is_write(done_is_write),
        .moved_cnt(moved_cnt), .next_head(next_head), .bank_we(bank_we),
        .bank_wdata(bank_wdata), .bank_row(bank_row), .pe_rvalid(pe_rvalid),
        .pe_rdata(pe_rdata)
    );

    int n_checks = 0;
    int n_fail = 0;
    int seq = 0;
    bit finished = 0;

    // expected outputs of the most recent request
    bit        e_done, e_isw;
    int        e_cnt, e_nhead;
    bit        e_we [N];
    bit        e_rv [N];
    logic [DW-1:0] e_wd [N];
    logic [DW-1:0] e_rd [N];
    int        e_row [N];

    function automatic logic [DW-1:0] elem(input int p);
        logic [DW-1:0] pp;
        pp = DW'(p % PMOD);
        return (pp * 32'd65537) ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk("R1 done_valid", 64'(done_valid), 64'(e_done));
        chk("R8 done_is_write", 64'(done_is_write), 64'(e_isw));
        chk("R2 moved_cnt", 64'(moved_cnt), 64'(e_cnt));
        chk("R3 next_head", 64'(next_head), 64'(e_nhead));
        for (int b = 0; b < N; b++) begin
            chk("R5 bank_we", 64'(bank_we[b]), 64'(e_we[b]));
            chk("R4 bank_wdata", 64'(bank_wdata[b*DW +: DW]), 64'(e_wd[b]));
            chk("R4 bank_row", 64'(bank_row[b*RW +: RW]), 64'(e_row[b]));
        end
        for (int i = 0; i < N; i++) begin
            chk("R7 pe_rvalid", 64'(pe_rvalid[i]), 64'(e_rv[i]));
            chk("R6 pe_rdata", 64'(pe_rdata[i*DW +: DW]), 64'(e_rd[i]));
        end
        if (e_cnt == 0) begin
            chk("R9 quiet enables", 64'({bank_we, pe_rvalid}), 64'(0));
        end
    endtask

    task automatic apply(input bit v, input bit w, input int h, input logic [N-1:0] m);
        int k, hm, cnt;
        logic [DW-1:0] lwd [N];
        seq++;
        hm = h % PMOD;
        xfer_valid = v;
        xfer_write = w;
        head_pos = PW'(hm);
        lane_mask = m;
        for (int i = 0; i < N; i++) begin
            lwd[i] = 32'hC000_0000 | DW'(seq << 8) | DW'(i);
            pe_wdata[i*DW +: DW] = lwd[i];
        end
        for (int b = 0; b < N; b++) begin
            int pos;
            pos = (hm + ((b - (hm % N) + N) % N)) % PMOD;
            bank_rdata[b*DW +: DW] = elem(pos);
            e_row[b] = v ? (pos >> IW) : 0;
            e_we[b] = 0; e_wd[b] = '0; e_rv[b] = 0; e_rd[b] = '0;
        end
        cnt = 0;
        for (int i = 0; i < N; i++) cnt += int'(m[i]);
        e_done = v;
        e_isw = v & w;
        e_cnt = v ? cnt : 0;
        if (v) e_nhead = (hm + cnt) % PMOD;
        if (v) begin
            k = 0;
            for (int i = 0; i < N; i++) begin
                if (m[i]) begin
                    if (w) begin
                        e_we[(hm + k) % N] = 1;
                        e_wd[(hm + k) % N] = lwd[i];
                    end else begin
                        e_rv[i] = 1;
                        e_rd[i] = elem(hm + k);
                    end
                    k++;
                end
            end
        end
    endtask

    task automatic step(input bit v, input bit w, input int h, input logic [N-1:0] m);
        @(negedge clk);
        compare();
        apply(v, w, h, m);
    endtask

    initial begin
        e_done = 0; e_isw = 0; e_cnt = 0; e_nhead = 0;
        for (int b = 0; b < N; b++) begin
            e_we[b] = 0; e_rv[b] = 0; e_wd[b] = '0; e_rd[b] = '0; e_row[b] = 0;
        end
        repeat (2) @(negedge clk);
        // R10: reset state
        chk("R10 done_valid", 64'(done_valid), 64'(0));
        chk("R10 bank_we", 64'(bank_we), 64'(0));
        chk("R10 pe_rvalid", 64'(pe_rvalid), 64'(0));
        chk("R10 moved_cnt", 64'(moved_cnt), 64'(0));
        chk("R10 next_head", 64'(next_head), 64'(0));
        chk("R10 data", 64'(bank_wdata ^ pe_rdata), 64'(0));
        rst_n = 1'b1;
        step(1, 1, 0, 4'b1111);        // R4 full write aligned
        step(1, 1, 3, 4'b1010);        // R4/R5 sparse write wrapping bank 3 -> 0
        step(1, 1, 5, 4'b0000);        // R9 empty write
        step(1, 0, 6, 4'b1111);        // R6 full read
        step(1, 0, 7, 4'b0110);        // R6/R7 sparse read across banks
        step(1, 0, 9, 4'b0000);        // R9 empty read
        step(0, 1, 9, 4'b1111);        // R9 idle with mask set
        step(1, 1, 16'hFFFE, 4'b1101); // R3/R4 position wrap with bank wrap
        step(1, 0, 16'hFFFF, 4'b1001); // R6 position wrap on read
        step(1, 1, 16'hFFFD, 4'b1000); // R4 single lane, last lane
        step(1, 0, 2, 4'b0001);        // R8 direction flip back to back
        for (int t = 0; t < 400; t++) begin
            bit v, w;
            int h;
            v = ($urandom % 5) != 0;
            w = $urandom % 2;
            h = (($urandom % 4) == 0) ? int'($urandom % PMOD) : e_nhead;
            step(v, w, h, N'($urandom));
        end
        step(0, 0, 0, '0);
        step(0, 0, 0, '0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule